// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits between a host controller's transmit pin and the enable of a single-wire bus low-side driver. A low transmit level pulls the bus dominant and a high level leaves it recessive. The transmit level is passed through only while the transceiver reports normal mode and the supply is not in undervoltage.

The block cuts the driver off if the transmit level stays low for longer than a programmable number of timebase ticks. It also holds the driver off after every entry into normal mode. In both cases the driver is enabled again only once the transmit level has stayed high for a qualified number of ticks. A single rising edge is not enough.

The block runs as a four-state machine:

- **IDLE**: not in normal mode, or in undervoltage. This is the reset state. The driver is off.
- **QUALIFY**: the transceiver has entered normal mode and the block is counting high time on the transmit level. The driver is off.
- **ARMED**: the driver follows the inverted transmit level, and the block counts low time.
- **TIMEOUT**: the low time ran out. The driver is off and the timeout flag is raised while the block counts high time.

The transitions are:

- **IDLE → QUALIFY** when normal mode is present with no undervoltage.
- **QUALIFY → ARMED** and **TIMEOUT → ARMED** when the high time reaches `REARM_TICKS`.
- **ARMED → TIMEOUT** when the low time reaches `DOM_TICKS`.
- **any → IDLE** when normal mode drops or undervoltage is raised.

Top module: `tx_dom_guard`

## Requirements
- R1: In ARMED, `drv_on_o` is the inverse of `tx_level_i` delayed by the two-flop synchroniser. A change at the input appears at the output after two clock edges.
- R2: A synchronised low level held across `DOM_TICKS` tick cycles ends driving. When the tick is high on every cycle, `drv_on_o` stays high for exactly min(L, `DOM_TICKS`) cycles for a low pulse of L cycles. A pulse of `DOM_TICKS` cycles or longer causes a timeout.
- R3: After a timeout, the driver stays off until the synchronised level has been high for `REARM_TICKS` tick cycles. When the tick is high on every cycle, the timeout flag stays high for L − `DOM_TICKS` + `REARM_TICKS` cycles.
- R4: After entry into normal mode, the driver stays off until the level has been high for `REARM_TICKS` ticks. A high stretch of fewer cycles leaves the driver off when the level returns low.
- R5: While `uv_i` is 1, `drv_on_o` is 0 in the same cycle. After `uv_i` clears, driving waits for a new qualification (R4).
- R6: While `normal_i` is 0, `drv_on_o` is 0. Leaving normal mode clears `timeout_o` on the next edge.
- R7: During reset both outputs are 0 and the block is not armed.
- R8: `timeout_o` is high from the timeout edge until re-arm completes, and the driver is never on while it is high.
- R9: The counters advance only on cycles where `tick_i` is 1. With the tick held at 0, a held low level never times out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_level_i | input | 1 | Raw transmit level from the controller (0 = dominant) |
| normal_i | input | 1 | Transceiver is in normal mode |
| uv_i | input | 1 | Supply undervoltage flag |
| tick_i | input | 1 | Timebase pulse, one per microsecond |
| drv_on_o | output | 1 | Low-side driver enable |
| timeout_o | output | 1 | Dominant timeout has tripped and re-arm is pending |

## Verification
The checker watches the following on every cycle:

- The driver is off outside normal mode, in undervoltage and while the timeout flag is high.
- Whenever the driver is on, the transmit level seen two edges earlier was low.
- A continuous driving stretch never exceeds `DOM_TICKS` ticks.
- A timeout rises only directly after a driving cycle.

The exact length of the driving stretch and of the flag, and whether a given high stretch qualifies, are only visible through the bench's sweeps. These sweeps vary the low-pulse length across the timeout boundary and the high-stretch length across the re-arm boundary, and the bench computes the expected cycle counts from them.

// File: rtl/txg_pkg.sv
package txg_pkg;

    typedef enum logic [1:0] {
        TXG_IDLE    = 2'd0,
        TXG_QUALIFY = 2'd1,
        TXG_ARMED   = 2'd2,
        TXG_TIMEOUT = 2'd3
    } txg_state_e;

endpackage

// File: rtl/txg_sync.sv
module txg_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[gi] <= RESET_VAL;
                    else        chain_q[gi] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[gi] <= RESET_VAL;
                    else        chain_q[gi] <= chain_q[gi-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/txg_span_counter.sv
module txg_span_counter #(
    parameter int LIMIT = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    output logic done_o
);

    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] span_q;

    assign done_o = run_i && tick_i && (span_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            span_q <= '0;
        end else if (!run_i || done_o) begin
            span_q <= '0;
        end else if (tick_i) begin
            span_q <= span_q + 1'b1;
        end
    end

endmodule

// File: rtl/tx_dom_guard.sv
module tx_dom_guard #(
    parameter int DOM_TICKS   = 55000,
    parameter int REARM_TICKS = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_level_i,
    input  logic normal_i,
    input  logic uv_i,
    input  logic tick_i,
    output logic drv_on_o,
    output logic timeout_o
);
    import txg_pkg::*;

    txg_state_e state_q, state_d;
    logic       tx_sync;
    logic       link_ok;
    logic       dom_run, dom_done;
    logic       qual_run, qual_done;

    txg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (tx_level_i),
        .q_o   (tx_sync)
    );

    assign link_ok  = normal_i && !uv_i;
    assign dom_run  = (state_q == TXG_ARMED) && !tx_sync;
    assign qual_run = ((state_q == TXG_QUALIFY) || (state_q == TXG_TIMEOUT)) && tx_sync;

    txg_span_counter #(.LIMIT(DOM_TICKS)) u_dom_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (dom_run),
        .tick_i (tick_i),
        .done_o (dom_done)
    );

    txg_span_counter #(.LIMIT(REARM_TICKS)) u_qual_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (qual_run),
        .tick_i (tick_i),
        .done_o (qual_done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TXG_IDLE: begin
                if (link_ok) state_d = TXG_QUALIFY;
            end
            TXG_QUALIFY: begin
                if (!link_ok)       state_d = TXG_IDLE;
                else if (qual_done) state_d = TXG_ARMED;
            end
            TXG_ARMED: begin
                if (!link_ok)      state_d = TXG_IDLE;
                else if (dom_done) state_d = TXG_TIMEOUT;
            end
            TXG_TIMEOUT: begin
                if (!link_ok)       state_d = TXG_IDLE;
                else if (qual_done) state_d = TXG_ARMED;
            end
            default: state_d = TXG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TXG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        drv_on_o  = 1'b0;
        timeout_o = 1'b0;
        unique case (state_q)
            TXG_IDLE:    ;
            TXG_QUALIFY: ;
            TXG_ARMED:   drv_on_o  = link_ok && !tx_sync;
            TXG_TIMEOUT: timeout_o = 1'b1;
            default:     ;
        endcase
    end

endmodule

// File: rtl/tx_dom_guard_chk.sv
module tx_dom_guard_chk #(
    parameter int DOM_TICKS = 55000
) (
    input logic clk,
    input logic rst_n,
    input logic tx_level_i,
    input logic normal_i,
    input logic uv_i,
    input logic tick_i,
    input logic drv_on_o,
    input logic timeout_o
);
    localparam int CW = $clog2(DOM_TICKS + 2);

    logic [CW-1:0] drive_ticks_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            drive_ticks_q <= '0;
        else if (!drv_on_o)    drive_ticks_q <= '0;
        else if (tick_i)       drive_ticks_q <= drive_ticks_q + 1'b1;
    end

    p_drive_follows_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        drv_on_o |-> !$past(tx_level_i, 2));

    p_drive_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        drive_ticks_q <= CW'(DOM_TICKS));

    p_timeout_after_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> $past(drv_on_o));

    p_off_in_uv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        uv_i |-> !drv_on_o);

    p_off_outside_normal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !normal_i |-> !drv_on_o);

    p_flag_blocks_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> !drv_on_o);

endmodule

bind tx_dom_guard tx_dom_guard_chk #(.DOM_TICKS(DOM_TICKS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_level_i (tx_level_i),
    .normal_i   (normal_i),
    .uv_i       (uv_i),
    .tick_i     (tick_i),
    .drv_on_o   (drv_on_o),
    .timeout_o  (timeout_o)
);

// File: tb/tx_dom_guard_bench.sv
module tx_dom_guard_bench;

    localparam int D = 12;
    localparam int R = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx = 1'b0;
    logic normal = 1'b1;
    logic uv = 1'b0;
    logic tick = 1'b1;
    logic drv_on, tmo;
    int   tick_mode = 0;
    int   ph = 0;
    int   errors = 0;
    int   checks = 0;
    bit   finished = 1'b0;

    always #10 clk = ~clk;

    tx_dom_guard #(.DOM_TICKS(D), .REARM_TICKS(R)) u_tx_dom_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_level_i (tx),
        .normal_i   (normal),
        .uv_i       (uv),
        .tick_i     (tick),
        .drv_on_o   (drv_on),
        .timeout_o  (tmo)
    );

    always @(negedge clk) begin
        ph   <= (ph + 1) % 4;
        tick <= (tick_mode == 0) ? 1'b1 : (tick_mode == 1) ? 1'b0 : (ph == 0);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_low(input int len);
        int ndrv = 0;
        int ntmo = 0;
        int exp_d, exp_t;
        tx = 1'b0;
        for (int n = 0; n < len + R + 12; n++) begin
            @(negedge clk);
            if (drv_on) ndrv++;
            if (tmo) ntmo++;
            if (n == len - 1) tx = 1'b1;
        end
        exp_d = (len < D) ? len : D;
        exp_t = (len < D) ? 0 : len - D + R;
        check(ndrv == exp_d, "R2 drive cycles", ndrv, exp_d);
        check(ntmo == exp_t, "R3 flag cycles", ntmo, exp_t);
        cyc(10);
    endtask

    initial begin
        int nd;
        cyc(3);
        check(drv_on == 1'b0, "R7 drv in reset", drv_on, 0);
        check(tmo == 1'b0, "R7 flag in reset", tmo, 0);
        rst_n = 1'b1;
        cyc(10);
        check(drv_on == 1'b0, "R4 low at normal entry", drv_on, 0);

        for (int h = 1; h <= R + 2; h++) begin
            normal = 1'b0; tx = 1'b0; cyc(3);
            check(drv_on == 1'b0, "R6 off outside normal", drv_on, 0);
            normal = 1'b1; cyc(3);
            tx = 1'b1; cyc(h);
            tx = 1'b0; cyc(3);
            check(drv_on == (h >= R), "R4 qualify sweep", drv_on, int'(h >= R));
        end
        tx = 1'b1; cyc(10);

        for (int len = 1; len <= D + 4; len++) pulse_low(len);

        tx = 1'b0; cyc(4);
        check(drv_on == 1'b1, "R1 drive follows low", drv_on, 1);
        uv = 1'b1; #1;
        check(drv_on == 1'b0, "R5 uv same cycle", drv_on, 0);
        cyc(2); uv = 1'b0; cyc(10);
        check(drv_on == 1'b0, "R5 requalify after uv", drv_on, 0);
        tx = 1'b1; cyc(10); tx = 1'b0; cyc(4);
        check(drv_on == 1'b1, "R1 drive after requalify", drv_on, 1);
        normal = 1'b0; #1;
        check(drv_on == 1'b0, "R6 off when normal drops", drv_on, 0);
        normal = 1'b1; tx = 1'b1; cyc(10);

        tx = 1'b0; cyc(D + 5);
        check(tmo == 1'b1, "R8 flag after timeout", tmo, 1);
        check(drv_on == 1'b0, "R8 drv off in timeout", drv_on, 0);
        normal = 1'b0; cyc(2);
        check(tmo == 1'b0, "R6 flag cleared", tmo, 0);
        normal = 1'b1; tx = 1'b1; cyc(10); tx = 1'b0; cyc(4);
        check(drv_on == 1'b1, "R4 rearm after reentry", drv_on, 1);
        tx = 1'b1; cyc(10);

        tick_mode = 1; cyc(2);
        tx = 1'b0; cyc(3 * D);
        check(drv_on == 1'b1, "R9 no tick keeps drive", drv_on, 1);
        check(tmo == 1'b0, "R9 no tick no timeout", tmo, 0);
        tick_mode = 0; cyc(D + 3);
        check(tmo == 1'b1, "R9 timeout once ticks resume", tmo, 1);
        tx = 1'b1; cyc(10);

        tick_mode = 2; cyc(8);
        tx = 1'b0; nd = 0;
        for (int n = 0; n < 6 * D; n++) begin
            @(negedge clk);
            if (drv_on) nd++;
        end
        check(nd >= 4 * (D - 1) && nd <= 4 * D + 4, "R9 sparse tick span", nd, 4 * D);
        check(tmo == 1'b1, "R2 sparse tick timeout", tmo, 1);
        tx = 1'b1; tick_mode = 0; cyc(10);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule